// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept or dropped, judging only by its 48-bit destination address. The address arrives as six bytes, one per clock, on a byte strobe. The first byte carries a start flag. While the bytes stream in, the block runs a byte-wide reflected CRC-32 over them and shifts the address into a register. One cycle after the sixth byte it issues a single-cycle `dec_valid` pulse together with the accept/reject verdict. The verdict stays on `dec_accept` until the next start flag.

Unicast destinations are compared against a small table of perfect-match entries. Each entry has its own enable bit, and entry 0 holds the station's own address. Group (multicast) destinations are sent to a hash table of `HASH_BINS` bins, where `HASH_BINS` is 64, 128 or 256. The hash bin index is the top log2(`HASH_BINS`) bits of the bit-reversed complement of the CRC. Index bits 5 and up pick a 32-bit table word, and index bits 4:0 pick the bit inside that word. Mode inputs stack on top of this, in priority order: receive-all, promiscuous, broadcast blocking, pass-all-multicast, and hash-multicast. Software fills both tables through two simple write ports.

The control is a four-state machine:
- `ST_IDLE`: the state after reset.
- `ST_COLLECT`: address bytes are being taken in.
- `ST_DECIDE`: the verdict cycle.
- `ST_HOLD`: the verdict is held.

The transitions are:
- start → `ST_COLLECT`, taken from any state.
- sixth byte in `ST_COLLECT` → `ST_DECIDE`.
- `ST_DECIDE` → `ST_HOLD`, unconditionally.
- Any other case keeps the current state.

Top module: `rx_da_filter`

## Requirements
- R1: The hash index is formed in these steps. First, take the reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the six address bytes, first byte first and LSB first within each byte. Second, complement the result. Third, bit-reverse it across 32 bits. Finally, take the top log2(HASH_BINS) bits. Index bits 5 and up select the table word written at `ht_wr_word`, and index bits 4:0 select the bit in that word.
- R2: In hash-multicast mode, a non-broadcast group frame is accepted exactly when its hash bin bit is 1.
- R3: In pass-all-multicast mode, every non-broadcast group frame is accepted, whatever the hash table holds.
- R4: In promiscuous mode, every frame is accepted.
- R5: In receive-all mode, every frame is accepted.
- R6: A unicast frame is accepted when its address equals an enabled perfect entry. In every perfect entry and in the address register, the first received byte sits in bits 7:0.
- R7: A perfect entry written with `pf_wr_valid`=0 never matches.
- R8: The broadcast address (all ones) is accepted unless `cfg_bcast_block` is 1. With blocking on, broadcast is rejected unless promiscuous or receive-all is on.
- R9: A frame is a group frame when bit 0 of its first byte is 1. A non-broadcast group frame is rejected when both pass-all-multicast and hash-multicast are off.
- R10: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte.
- R11: `dec_accept` keeps its verdict until the next start byte and is 0 from then until the next verdict.
- R12: After reset, `dec_valid` and `dec_accept` are 0, the hash table is all zero and every perfect entry is disabled.
- R13: A start byte that arrives in the middle of an address restarts collection from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| da_valid | input | 1 | Address byte strobe |
| da_first | input | 1 | Marks the first address byte (start) |
| da_byte | input | 8 | Address byte |
| cfg_rx_all | input | 1 | Receive-all debug mode |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_pass_mcast | input | 1 | Pass all group frames |
| cfg_hash_mcast | input | 1 | Hash filtering of group frames |
| cfg_bcast_block | input | 1 | Reject broadcast |
| ht_wr_en | input | 1 | Hash table word write |
| ht_wr_word | input | log2(HASH_BINS/32) | Hash table word index |
| ht_wr_data | input | 32 | Hash table word value |
| pf_wr_en | input | 1 | Perfect entry write |
| pf_wr_idx | input | log2(NUM_PERFECT) | Perfect entry index |
| pf_wr_addr | input | 48 | Perfect entry address |
| pf_wr_valid | input | 1 | Perfect entry enable |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Verdict, held until next start |

## Verification
The bench keeps a model of both tables and computes the hash with a separate bit-serial CRC. It then hits every bin-word boundary by setting exactly the bit the model predicts and then clearing it. A design with a wrong reflection, a missing complement or a swapped word/bit split would accept with the bit clear or reject with it set. Broadcast sent with blocking on and pass-all on catches a design that gives group modes priority over blocking. A disabled entry that holds the exact address catches a design that ignores the enable bit. A start byte in the middle of an address catches a design that keeps counting: it would issue the verdict early, on a mixed address.

// File: rtl/daf_pkg.sv
package daf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_HOLD    = 2'd3
    } daf_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam int          ADDR_BYTES    = 6;

    function automatic logic [31:0] crc_byte_step(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'd0, data};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/daf_crc.sv
module daf_crc #(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_first,
    input  logic                 load_next,
    input  logic [7:0]           data,
    output logic [HASH_BITS-1:0] hash_idx
);
    import daf_pkg::*;

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (load_first) begin
            crc_q <= crc_byte_step('1, data);
        end else if (load_next) begin
            crc_q <= crc_byte_step(crc_q, data);
        end
    end

    // top bits of the reversed complement are the low bits of the complement, reversed
    for (genvar i = 0; i < HASH_BITS; i++) begin : g_idx
        assign hash_idx[i] = ~crc_q[HASH_BITS-1-i];
    end
endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table #(
    parameter int HASH_BINS = 64,
    localparam int HASH_BITS = $clog2(HASH_BINS),
    localparam int WORDS     = HASH_BINS / 32,
    localparam int WORD_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [31:0]          wr_data,
    input  logic [HASH_BITS-1:0] idx,
    output logic                 hit
);
    logic [31:0] words_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else if (wr_en && (wr_word == WORD_W'(w))) begin
                words_q[w] <= wr_data;
            end
        end
    end

    assign hit = words_q[idx[HASH_BITS-1:5]][idx[4:0]];
endmodule

// File: rtl/daf_perfect_match.sv
module daf_perfect_match #(
    parameter int NUM_PERFECT = 4,
    localparam int IDX_W = (NUM_PERFECT > 1) ? $clog2(NUM_PERFECT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [47:0]      wr_addr,
    input  logic             wr_valid,
    input  logic [47:0]      da,
    output logic             hit
);
    logic [47:0]            addr_q [NUM_PERFECT];
    logic [NUM_PERFECT-1:0] en_q;
    logic [NUM_PERFECT-1:0] match;

    for (genvar e = 0; e < NUM_PERFECT; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[e] <= '0;
                en_q[e]   <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                addr_q[e] <= wr_addr;
                en_q[e]   <= wr_valid;
            end
        end
        assign match[e] = en_q[e] && (addr_q[e] == da);
    end

    assign hit = |match;
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
    parameter int HASH_BINS   = 64,
    parameter int NUM_PERFECT = 4
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 da_valid,
    input  logic                                                 da_first,
    input  logic [7:0]                                           da_byte,
    input  logic                                                 cfg_rx_all,
    input  logic                                                 cfg_promisc,
    input  logic                                                 cfg_pass_mcast,
    input  logic                                                 cfg_hash_mcast,
    input  logic                                                 cfg_bcast_block,
    input  logic                                                 ht_wr_en,
    input  logic [((HASH_BINS/32 > 1) ? $clog2(HASH_BINS/32) : 1)-1:0] ht_wr_word,
    input  logic [31:0]                                          ht_wr_data,
    input  logic                                                 pf_wr_en,
    input  logic [((NUM_PERFECT > 1) ? $clog2(NUM_PERFECT) : 1)-1:0]   pf_wr_idx,
    input  logic [47:0]                                          pf_wr_addr,
    input  logic                                                 pf_wr_valid,
    output logic                                                 dec_valid,
    output logic                                                 dec_accept
);
    import daf_pkg::*;

    localparam int HASH_BITS = $clog2(HASH_BINS);
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1);

    daf_state_e           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [47:0]          da_q;
    logic                 acc_q;
    logic                 start, take_next;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 hash_hit, pf_hit;
    logic                 is_group, is_bcast, verdict;

    assign start     = da_valid && da_first;
    assign take_next = da_valid && !da_first && (state_q == ST_COLLECT);

    daf_crc #(.HASH_BITS(HASH_BITS)) crc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (start),
        .load_next  (take_next),
        .data       (da_byte),
        .hash_idx   (hash_idx)
    );

    daf_hash_table #(.HASH_BINS(HASH_BINS)) hash_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ht_wr_en),
        .wr_word (ht_wr_word),
        .wr_data (ht_wr_data),
        .idx     (hash_idx),
        .hit     (hash_hit)
    );

    daf_perfect_match #(.NUM_PERFECT(NUM_PERFECT)) pf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pf_wr_en),
        .wr_idx   (pf_wr_idx),
        .wr_addr  (pf_wr_addr),
        .wr_valid (pf_wr_valid),
        .da       (da_q),
        .hit      (pf_hit)
    );

    // address capture: first byte lands in bits 7:0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            da_q  <= '0;
        end else if (start) begin
            cnt_q       <= CNT_W'(1);
            da_q[7:0]   <= da_byte;
        end else if (take_next) begin
            cnt_q              <= cnt_q + CNT_W'(1);
            da_q[cnt_q*8 +: 8] <= da_byte;
        end
    end

    // verdict with mode priority
    assign is_group = da_q[0];
    assign is_bcast = &da_q;
    always_comb begin
        if (cfg_rx_all || cfg_promisc) begin
            verdict = 1'b1;
        end else if (is_bcast) begin
            verdict = !cfg_bcast_block;
        end else if (is_group) begin
            verdict = cfg_pass_mcast || (cfg_hash_mcast && hash_hit);
        end else begin
            verdict = pf_hit;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                acc_q <= 1'b0;
            end else if (state_q == ST_DECIDE) begin
                acc_q <= verdict;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: if (take_next && cnt_q == CNT_W'(ADDR_BYTES - 1)) state_d = ST_DECIDE;
                ST_DECIDE:  state_d = ST_HOLD;
                ST_HOLD:    state_d = ST_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        dec_valid  = 1'b0;
        dec_accept = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COLLECT: ;
            ST_DECIDE: begin
                dec_valid  = 1'b1;
                dec_accept = verdict;
            end
            ST_HOLD:    dec_accept = acc_q;
        endcase
    end

    AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(da_valid)) else $error("valid without byte"); // R10
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid) else $error("valid longer than a cycle"); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !start) |=> $stable(dec_accept)) else $error("accept changed in hold"); // R11
    AST_QUIET_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT) |-> (!dec_accept && !dec_valid)) else $error("accept while collecting"); // R11
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (cfg_promisc || cfg_rx_all)) |-> dec_accept) else $error("promisc rejected"); // R4
    AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && is_bcast && cfg_bcast_block && !cfg_promisc && !cfg_rx_all) |-> !dec_accept)
        else $error("blocked broadcast accepted"); // R8
endmodule

// File: tb/rx_da_filter_tb_top.sv
`timescale 1ns/1ps
module rx_da_filter_tb_top;
    localparam int BINS  = 64;
    localparam int NPF   = 4;
    localparam int WORDS = BINS / 32;
    localparam int HBITS = $clog2(BINS);
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic da_valid = 0, da_first = 0;
    logic [7:0] da_byte = 0;
    logic cfg_rx_all = 0, cfg_promisc = 0, cfg_pass_mcast = 0, cfg_hash_mcast = 0, cfg_bcast_block = 0;
    logic ht_wr_en = 0;
    logic [0:0] ht_wr_word = 0;
    logic [31:0] ht_wr_data = 0;
    logic pf_wr_en = 0;
    logic [1:0] pf_wr_idx = 0;
    logic [47:0] pf_wr_addr = 0;
    logic pf_wr_valid = 0;
    logic dec_valid, dec_accept;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] ht_m [WORDS];
    logic [47:0] pf_addr_m [NPF];
    logic        pf_en_m [NPF];

    always #2 clk = ~clk;

    rx_da_filter #(.HASH_BINS(BINS), .NUM_PERFECT(NPF)) dut_i (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
        .cfg_rx_all(cfg_rx_all), .cfg_promisc(cfg_promisc), .cfg_pass_mcast(cfg_pass_mcast),
        .cfg_hash_mcast(cfg_hash_mcast), .cfg_bcast_block(cfg_bcast_block),
        .ht_wr_en(ht_wr_en), .ht_wr_word(ht_wr_word), .ht_wr_data(ht_wr_data),
        .pf_wr_en(pf_wr_en), .pf_wr_idx(pf_wr_idx), .pf_wr_addr(pf_wr_addr), .pf_wr_valid(pf_wr_valid),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit-serial reflected CRC, then complement, reverse and take top bits
    function automatic int ref_idx(input logic [47:0] da);
        logic [31:0] c = '1;
        logic [31:0] r;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[0] ^ da[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        c = ~c;
        for (int b = 0; b < 32; b++) r[b] = c[31-b];
        return int'(r >> (32 - HBITS));
    endfunction

    function automatic bit ref_accept(input logic [47:0] da);
        int ix;
        if (cfg_rx_all || cfg_promisc) return 1'b1;
        if (da == BCAST) return !cfg_bcast_block;
        if (da[0]) begin
            ix = ref_idx(da);
            return cfg_pass_mcast || (cfg_hash_mcast && ht_m[ix / 32][ix % 32]);
        end
        for (int e = 0; e < NPF; e++)
            if (pf_en_m[e] && pf_addr_m[e] == da) return 1'b1;
        return 1'b0;
    endfunction

    task automatic ht_write(input int w, input logic [31:0] v);
        @(negedge clk);
        ht_wr_en = 1; ht_wr_word = w[0:0]; ht_wr_data = v;
        @(negedge clk);
        ht_wr_en = 0;
        ht_m[w] = v;
    endtask

    task automatic pf_write(input int e, input logic [47:0] a, input bit en);
        @(negedge clk);
        pf_wr_en = 1; pf_wr_idx = e[1:0]; pf_wr_addr = a; pf_wr_valid = en;
        @(negedge clk);
        pf_wr_en = 0;
        pf_addr_m[e] = a; pf_en_m[e] = en;
    endtask

    task automatic push_bytes(input logic [47:0] da, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            da_valid = 1; da_first = (i == 0); da_byte = da[i*8 +: 8];
        end
    endtask

    // sends one address and checks the verdict cycle and one hold cycle
    task automatic send(input logic [47:0] da, input string req);
        bit exp = ref_accept(da);
        push_bytes(da, 6);
        @(negedge clk);
        da_valid = 0; da_first = 0;
        chk({req, " R10 valid"}, {31'd0, dec_valid}, 32'd1);
        chk({req, " verdict"}, {31'd0, dec_accept}, {31'd0, exp});
        @(negedge clk);
        chk("R10 pulse ends", {31'd0, dec_valid}, 32'd0);
        chk("R11 held", {31'd0, dec_accept}, {31'd0, exp});
    endtask

    task automatic set_modes(input bit ra, input bit pr, input bit pm, input bit hm, input bit bb);
        cfg_rx_all = ra; cfg_promisc = pr; cfg_pass_mcast = pm; cfg_hash_mcast = hm; cfg_bcast_block = bb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta, mc;
        int ix;
        void'($urandom(32'h5EED_0017));
        for (int w = 0; w < WORDS; w++) ht_m[w] = '0;
        for (int e = 0; e < NPF; e++) begin pf_addr_m[e] = '0; pf_en_m[e] = 0; end
        repeat (3) @(negedge clk);
        chk("R12 reset valid", {31'd0, dec_valid}, 32'd0);
        chk("R12 reset accept", {31'd0, dec_accept}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R12: empty tables reject unicast and hashed multicast
        sta = 48'h5544_3322_1100;
        set_modes(0, 0, 0, 1, 0);
        send(sta, "R12 empty perfect");
        send(48'h0000_0000_5E01, "R12 empty hash");

        // R6 station address in entry 0, R7 disabled entry
        pf_write(0, sta, 1);
        send(sta, "R6 station");
        pf_write(2, 48'hAA00_0000_0002, 0);
        send(48'hAA00_0000_0002, "R7 disabled");
        chk("R7 disabled rejects", {31'd0, dec_accept}, 32'd0);
        pf_write(2, 48'hAA00_0000_0002, 1);
        send(48'hAA00_0000_0002, "R6 entry2");
        chk("R6 entry2 accepted", {31'd0, dec_accept}, 32'd1);

        // R1/R2 directed bins in both words
        for (int t = 0; t < 8; t++) begin
            mc = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
            mc[0] = 1'b1;
            if (mc == BCAST) mc[1] = 1'b0;
            ix = ref_idx(mc);
            ht_write(ix / 32, 32'd1 << (ix % 32));
            send(mc, "R1 bin set");
            chk("R2 set bin accepts", {31'd0, dec_accept}, 32'd1);
            ht_write(ix / 32, ~(32'd1 << (ix % 32)));
            send(mc, "R1 bin clear");
            chk("R2 clear bin rejects", {31'd0, dec_accept}, 32'd0);
        end

        // R9 group with both group modes off
        ht_write(0, '1); ht_write(1, '1);
        set_modes(0, 0, 0, 0, 0);
        send(48'h1234_5678_9A01, "R9 no group mode");
        chk("R9 rejected", {31'd0, dec_accept}, 32'd0);
        // R3 pass-all with empty hash
        ht_write(0, '0); ht_write(1, '0);
        set_modes(0, 0, 1, 0, 0);
        send(48'h1234_5678_9A01, "R3 pass all");
        // R8 broadcast
        set_modes(0, 0, 0, 0, 0);
        send(BCAST, "R8 bcast open");
        set_modes(0, 0, 1, 1, 1);
        send(BCAST, "R8 bcast blocked");
        set_modes(0, 1, 0, 0, 1);
        send(BCAST, "R8 R4 promisc over block");
        // R4 R5
        send(48'h0F0E_0D0C_0B0A, "R4 promisc unicast");
        set_modes(1, 0, 0, 0, 1);
        send(48'h0F0E_0D0C_0B0A, "R5 rx all");

        // R13 restart mid-address, R11 accept drops on start
        set_modes(0, 0, 0, 0, 0);
        send(sta, "R11 prep");
        push_bytes(48'hDEAD_BEEF_0000, 1);
        @(negedge clk);
        da_valid = 0;
        chk("R11 cleared on start", {31'd0, dec_accept}, 32'd0);
        push_bytes(48'hDEAD_BEEF_0000, 3);
        send(sta, "R13 restart");
        chk("R13 accepted", {31'd0, dec_accept}, 32'd1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [47:0] a;
            int kind = $urandom_range(0, 3);
            if ($urandom_range(0, 9) == 0) ht_write($urandom_range(0, WORDS - 1), $urandom());
            if ($urandom_range(0, 14) == 0)
                pf_write($urandom_range(0, NPF - 1), {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFE, $urandom_range(0, 1) != 0);
            set_modes($urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
                      $urandom_range(0, 5) == 0, $urandom_range(0, 1) != 0, $urandom_range(0, 3) == 0);
            a = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
            case (kind)
                0: a = pf_addr_m[$urandom_range(0, NPF - 1)];
                1: a = BCAST;
                2: a[0] = 1'b1;
                default: a[0] = 1'b0;
            endcase
            send(a, "R1 R2 R6 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule